// File: doc/BRIEF.md
# Page-Addressed Monochrome Display Controller

This block drives a 128 by 64 display with one bit per pixel. A host talks to it through a small register window. It first picks a mode by writing a magic word to a mode register. It then writes instruction and data bytes. Page-select commands choose one of eight horizontal bands of eight rows each. In data mode, each data byte lands in the display memory at the current page and column, and the column steps forward by one, wrapping inside the page.

A separate scan-out port lets the pixel pipeline request any pixel by its x and y coordinates. One clock later the block returns a 24-bit colour. A lit pixel gives a fixed pale blue foreground, with each channel dimmed by a 3-bit brightness level. An unlit pixel gives black. An interrupt-control word can be written and read back. Every other register reads as zero.

Top module: `mono_lcd_ctrl`

## Requirements
- R1: After reset the mode is invalid, the page and column are 0, the interrupt-control word reads 0, and pixValid is low.
- R2: A mode-register write (offset 0x1AC) of exactly 0x00100011 selects data mode, and exactly 0x00104011 selects command mode. Any other value, including near misses, selects the invalid mode. In the invalid mode, data-register writes change neither the display memory nor the page or column.
- R3: An instruction-register write (offset 0x1BC) of a value from 0xB0 to 0xB7 selects page (value − 0xB0) and sets the column to 0. Any other value is ignored.
- R4: In command mode, a data-register write (offset 0x1C0) of a value from 0xB0 to 0xB7 selects the page and clears the column. Other values are ignored and never reach the memory.
- R5: In data mode, a data-register write stores bits 7:0 of the value at byte address page*128 + column. The column then advances modulo 128, so the write after column 127 goes to column 0 of the same page.
- R6: The interrupt-control word at offset 0x180 is 32 bits and readable and writable. A read of any other offset, including the mode, instruction and data registers, returns 0. The read data depends on the address alone.
- R7: A scan request for (x, y) returns pixValid high on the next cycle, with the pixel taken from bit (y mod 8) of byte x + (y/8)*128. With no request, pixValid is low on the next cycle.
- R8: pixRgb is {red[23:16], green[15:8], blue[7:0]}. A lit pixel gives floor(c*level/7) for each channel c of 0xE0E0FF, using the level registered with the request. An unlit pixel gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Register write value |
| regRdData | output | 32 | Register read value for regAddr |
| scanReq | input | 1 | Pixel read request |
| scanX | input | 7 | Pixel column 0..127 |
| scanY | input | 6 | Pixel row 0..63 |
| level | input | 3 | Brightness level 0..7 |
| pixValid | output | 1 | Pixel result valid, one cycle after scanReq |
| pixRgb | output | 24 | Scaled pixel colour |

## Verification
The bench uses the default parameters: a 12-bit offset space, 32-bit register words and the full 32-bit magic words. This lets it show that a word differing from a magic word in only its lowest bit falls into the invalid mode. With the full 128-column page it can write 129 bytes in a row, so the column wrap back to the start of the same page comes into reach. All eight brightness levels can be applied against the foreground, including the level-0 black and the non-integer blue steps.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int COL_W     = 7;
  localparam int PAGE_W    = 3;
  localparam int BIT_W     = 3;
  localparam int ROW_W     = PAGE_W + BIT_W;
  localparam int MADDR_W   = PAGE_W + COL_W;
  localparam int MEM_BYTES = 1 << MADDR_W;
  localparam int LVL_W     = 3;
  localparam int CHAN_W    = 8;
  localparam int NCHAN     = 3;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_DATA = 2'd1,
    MODE_CMD  = 2'd2
  } modeT;

  typedef struct packed {
    logic               memWr;
    logic [MADDR_W-1:0] memAddr;
    logic [7:0]         memByte;
  } memStrobeT;
endpackage

// File: rtl/lcd_ctrl.sv
module lcd_ctrl
  import lcd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFF_IRQ  = 'h180,
  parameter logic [ADDR_W-1:0] OFF_MODE = 'h1AC,
  parameter logic [ADDR_W-1:0] OFF_INST = 'h1BC,
  parameter logic [ADDR_W-1:0] OFF_DATA = 'h1C0,
  parameter logic [DATA_W-1:0] MAGIC_DATA = 'h00100011,
  parameter logic [DATA_W-1:0] MAGIC_CMD  = 'h00104011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output memStrobeT         strobe
);
  localparam logic [DATA_W-1:0] PG_FIRST = 'hB0;
  localparam logic [DATA_W-1:0] PG_LAST  = PG_FIRST + DATA_W'((1 << PAGE_W) - 1);

  modeT              mode;
  logic [PAGE_W-1:0] page;
  logic [COL_W-1:0]  col;
  logic [DATA_W-1:0] irqCtrl;

  logic hitIrq, hitMode, hitInst, hitData;
  logic isPage, setPage, storeByte;

  always_comb begin
    hitIrq    = wrEn && (addr == OFF_IRQ);
    hitMode   = wrEn && (addr == OFF_MODE);
    hitInst   = wrEn && (addr == OFF_INST);
    hitData   = wrEn && (addr == OFF_DATA);
    isPage    = (wrData >= PG_FIRST) && (wrData <= PG_LAST);
    setPage   = isPage && (hitInst || (hitData && mode == MODE_CMD));
    storeByte = hitData && (mode == MODE_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_OFF;
      page    <= '0;
      col     <= '0;
      irqCtrl <= '0;
    end else begin
      if (hitIrq) irqCtrl <= wrData;
      if (hitMode) begin
        if (wrData == MAGIC_DATA)     mode <= MODE_DATA;
        else if (wrData == MAGIC_CMD) mode <= MODE_CMD;
        else                          mode <= MODE_OFF;
      end
      if (setPage) begin
        page <= wrData[PAGE_W-1:0];
        col  <= '0;
      end else if (storeByte) begin
        col <= col + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.memWr   = storeByte;
    strobe.memAddr = {page, col};
    strobe.memByte = wrData[7:0];
    rdData         = (addr == OFF_IRQ) ? irqCtrl : '0;
  end

  AST_PAGE_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (hitInst && isPage) |=> (col == '0 && page == $past(wrData[PAGE_W-1:0]))); // R3
  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (storeByte && !setPage && col == '1) |=> (col == '0)); // R5
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (storeByte && !setPage && col != '1) |=> (col == COL_W'($past(col) + 1'b1))); // R5
  AST_OFF_NOWR: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF) |-> !strobe.memWr); // R2
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF && !hitInst) |=> ($stable(page) && $stable(col))); // R2
  AST_CMD_NOWR: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_CMD) |-> !strobe.memWr); // R4
endmodule

// File: rtl/lcd_datapath.sv
module lcd_datapath
  import lcd_pkg::*;
#(
  parameter logic [NCHAN*CHAN_W-1:0] FG_RGB = 24'hE0E0FF
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  memStrobeT                strobe,
  input  logic                     scanReq,
  input  logic [COL_W-1:0]         scanX,
  input  logic [ROW_W-1:0]         scanY,
  input  logic [LVL_W-1:0]         level,
  output logic                     pixValid,
  output logic [NCHAN*CHAN_W-1:0]  pixRgb
);
  localparam int PROD_W = CHAN_W + LVL_W;
  localparam int MAX_LVL = (1 << LVL_W) - 1;

  logic [7:0]       mem [MEM_BYTES];
  logic [7:0]       rdByte;
  logic [BIT_W-1:0] bitSel;
  logic [LVL_W-1:0] lvlQ;
  logic             litBit;

  always_ff @(posedge clk) begin
    if (strobe.memWr) mem[strobe.memAddr] <= strobe.memByte;
    if (scanReq) rdByte <= mem[{scanY[ROW_W-1:BIT_W], scanX}];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixValid <= 1'b0;
      bitSel   <= '0;
      lvlQ     <= '0;
    end else begin
      pixValid <= scanReq;
      if (scanReq) begin
        bitSel <= scanY[BIT_W-1:0];
        lvlQ   <= level;
      end
    end
  end

  assign litBit = rdByte[bitSel];

  for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;
    always_comb begin
      prod = PROD_W'(FG_RGB[ch*CHAN_W +: CHAN_W]) * PROD_W'(lvlQ);
      quot = prod / PROD_W'(MAX_LVL);
      pixRgb[ch*CHAN_W +: CHAN_W] = litBit ? quot[CHAN_W-1:0] : '0;
    end
  end

  AST_PIX_LAT: assert property (@(posedge clk) disable iff (!rstN)
    scanReq |=> pixValid); // R7
  AST_PIX_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !scanReq |=> !pixValid); // R7
  AST_LVL0_BLACK: assert property (@(posedge clk) disable iff (!rstN)
    (scanReq && level == '0) |=> (pixRgb == '0)); // R8
endmodule

// File: rtl/mono_lcd_ctrl.sv
module mono_lcd_ctrl
  import lcd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              scanReq,
  input  logic [COL_W-1:0]  scanX,
  input  logic [ROW_W-1:0]  scanY,
  input  logic [LVL_W-1:0]  level,
  output logic              pixValid,
  output logic [NCHAN*CHAN_W-1:0] pixRgb
);
  memStrobeT strobe;

  lcd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (regWrEn),
    .addr   (regAddr),
    .wrData (regWrData),
    .rdData (regRdData),
    .strobe (strobe)
  );

  lcd_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .scanReq  (scanReq),
    .scanX    (scanX),
    .scanY    (scanY),
    .level    (level),
    .pixValid (pixValid),
    .pixRgb   (pixRgb)
  );
endmodule

// File: tb/mono_lcd_ctrl_tb.sv
`timescale 1ns/1ps
module mono_lcd_ctrl_tb;
  localparam logic [11:0] A_IRQ = 12'h180, A_MODE = 12'h1AC,
                          A_INST = 12'h1BC, A_DATA = 12'h1C0;
  localparam logic [31:0] M_DATA = 32'h00100011, M_CMD = 32'h00104011;
  // pixel vectors: {x[6:0], y[5:0], level[2:0], lit}
  localparam int NVEC = 11;
  localparam logic [16:0] VEC [NVEC] = '{
    {7'd0, 6'd16, 3'd7, 1'b1}, {7'd0, 6'd17, 3'd7, 1'b0},
    {7'd0, 6'd18, 3'd5, 1'b1}, {7'd0, 6'd23, 3'd3, 1'b1},
    {7'd1, 6'd16, 3'd1, 1'b1}, {7'd1, 6'd17, 3'd6, 1'b0},
    {7'd0, 6'd56, 3'd4, 1'b1}, {7'd0, 6'd63, 3'd2, 1'b1},
    {7'd0, 6'd47, 3'd6, 1'b1}, {7'd0, 6'd40, 3'd7, 1'b0},
    {7'd0, 6'd57, 3'd0, 1'b1}
  };

  logic clk = 0, rstN = 0, regWrEn = 0, scanReq = 0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic [6:0] scanX = '0;
  logic [5:0] scanY = '0;
  logic [2:0] level = '0;
  logic pixValid;
  logic [23:0] pixRgb;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mono_lcd_ctrl u_dut (.*);

  function automatic logic [23:0] expRgb(input logic lit, input int lvl);
    int r, g, b;
    r = (224 * lvl) / 7; g = (224 * lvl) / 7; b = (255 * lvl) / 7;
    return lit ? {r[7:0], g[7:0], b[7:0]} : 24'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pix(input string tag, input int x, input int y, input int lvl, input logic lit);
    @(negedge clk);
    scanReq = 1; scanX = 7'(x); scanY = 6'(y); level = 3'(lvl);
    @(negedge clk);
    scanReq = 0;
    check({tag, " valid"}, {31'd0, pixValid}, 32'd1);
    check(tag, {8'd0, pixRgb}, {8'd0, expRgb(lit, lvl)});
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nChk++; nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd(A_IRQ, d); check("R1 irq reset", d, 0);
    check("R1 pixValid reset", {31'd0, pixValid}, 0);
    // R6 register window
    wr(A_IRQ, 32'hDEADBEEF);
    rd(A_IRQ, d); check("R6 irq readback", d, 32'hDEADBEEF);
    rd(A_MODE, d); check("R6 mode reads 0", d, 0);
    rd(A_DATA, d); check("R6 data reads 0", d, 0);
    rd(12'h184, d); check("R6 other reads 0", d, 0);
    // load: R2 R3 R4 R5
    wr(A_MODE, M_DATA);
    wr(A_INST, 32'hB2); wr(A_DATA, 32'hA5); wr(A_DATA, 32'h01);
    wr(A_INST, 32'hB7); wr(A_DATA, 32'hFF);
    wr(A_MODE, M_CMD);  wr(A_DATA, 32'hB5);
    wr(A_MODE, M_DATA); wr(A_DATA, 32'h80);
    // R7 R8 vector walk
    for (int i = 0; i < NVEC; i++)
      pix($sformatf("R7/R8 vec%0d", i), int'(VEC[i][16:10]), int'(VEC[i][9:4]),
          int'(VEC[i][3:1]), VEC[i][0]);
    // R7 idle cycle
    @(negedge clk);
    check("R7 idle no valid", {31'd0, pixValid}, 0);
    // R5 column wrap inside page 1
    wr(A_INST, 32'hB1);
    for (int i = 0; i < 128; i++) wr(A_DATA, 32'h00);
    wr(A_DATA, 32'h01);
    pix("R5 wrap col0", 0, 8, 7, 1);
    pix("R5 wrap col1", 1, 8, 7, 0);
    pix("R5 wrap col127", 127, 15, 7, 0);
    pix("R5 page2 kept", 0, 16, 7, 1);
    // R2 near-miss magic -> invalid, data ignored
    wr(A_INST, 32'hB2);
    wr(A_MODE, 32'h00100010);
    wr(A_DATA, 32'h00);
    pix("R2 invalid ignored", 0, 16, 7, 1);
    wr(A_MODE, M_DATA);
    wr(A_DATA, 32'h00);
    pix("R2 data mode restored", 0, 16, 7, 0);
    // R4 command mode page select and ignore
    wr(A_MODE, M_CMD); wr(A_DATA, 32'hB3);
    wr(A_MODE, M_DATA); wr(A_DATA, 32'h02);
    pix("R4 cmd page set", 0, 25, 7, 1);
    pix("R4 cmd page other bit", 0, 24, 7, 0);
    wr(A_MODE, M_CMD); wr(A_DATA, 32'h55);
    wr(A_MODE, M_DATA); wr(A_DATA, 32'h08);
    pix("R4 cmd non-page ignored", 1, 27, 7, 1);
    // R3 out-of-range instruction ignored
    wr(A_INST, 32'hB8); wr(A_DATA, 32'h10);
    pix("R3 inst B8 ignored", 2, 28, 7, 1);
    wr(A_INST, 32'hAF); wr(A_DATA, 32'h20);
    pix("R3 inst AF ignored", 3, 29, 7, 1);
    finishRun();
  end
endmodule